// File: doc/BRIEF.md
# USB 1.1 Host Controller Register File

This block is the software-visible register window of a full/low-speed USB host controller. It occupies 32 bytes of I/O space. A host writes and reads it over a simple 16-bit little-endian bus with a byte address and two byte strobes. The window holds:

- a command word and a status word;
- an interrupt enable word;
- the 11-bit frame number;
- a 32-bit frame list base in two halves;
- a start-of-frame timing byte;
- one status/control word for each root port.

A frame sequencer sits beside the block. It reads run/stop and halted from the block and pushes status events into it. It also steps the frame number once per frame. The port signalling logic feeds the block with the connect state, the low-speed flag and resume detection for each port. It receives the enable, reset and suspend controls in return. The block drives a level interrupt from the enabled status bits.

Register offsets are fixed because driver software decodes them:

| Offset | Register |
|---|---|
| 0x00 | command |
| 0x02 | status |
| 0x04 | interrupt enable |
| 0x06 | frame number |
| 0x08 | frame list base, low half |
| 0x0A | frame list base, high half |
| 0x0C | start-of-frame timing |
| 0x10 + 2·n | port n |

Bus address bit 0 is ignored, so each access selects a whole 16-bit word.

Top module: `usbhc_regs`

## Requirements
- R1: Command bits at offset 0x00 are:
  - bit 0: run/stop
  - bit 1: controller reset
  - bit 2: global reset
  - bit 3: enter global suspend
  - bit 4: force global resume

  A write with bit 1 set restores every register to its default and does not store bit 1. The defaults are: command 0x0000, status 0x0020, enable 0, frame 0, base 0, timing 0x40, and the writable port bits 0.
- R2: Status bits at offset 0x02 are:
  - bit 0: interrupt
  - bit 1: error interrupt
  - bit 2: resume detect
  - bit 3: host system error
  - bit 4: process error
  - bit 5: halted

  Writing 1 to any bit clears it. Bits 0 to 4 are set by the `sts_set` input, and an event wins over a clear in the same cycle.
- R3: A command write whose bit 0 rises from 0 to 1 clears halted. A command write with bit 0 low sets halted. Rewriting bit 0 as 1 while it is already 1 leaves halted unchanged.
- R4: The frame number is 11 bits wide and sits at offset 0x06. A write takes effect only while halted is set. While halted is clear, each `frame_adv` pulse adds one, modulo 2048. While halted is set, `frame_adv` has no effect.
- R5: The frame list base is written as two halves, at offsets 0x08 (low) and 0x0A (high). Its low 12 bits always read as zero.
- R6: The timing register at offset 0x0C keeps only the low byte of a write, and its high byte reads as zero. Its default is 0x40.
- R7: Port n sits at offset 0x10 + 2·n. Its bits are:

  | Bit | Meaning | Access |
  |---|---|---|
  | 0 | connect status | read-only |
  | 1 | connect change | read-only, write 1 to clear |
  | 2 | enable | writable |
  | 3 | enable change | read-only, write 1 to clear |
  | 4, 5 | reserved | read 0 |
  | 6 | resume detect | writable |
  | 7 | reserved | reads 1 |
  | 8 | low-speed device | read-only |
  | 9 | reset | writable |
  | 12 | suspend | writable |

  Bits in mask 0x01BB ignore writes, apart from the clear action on bits 1 and 3. Bits 9 to 15 are all writable.
- R8: Any change of a port's connect input sets connect change. A disconnect also clears enable and sets enable change. Writing 1 to bit 1 or bit 3 clears that bit.
- R9: A command write that sets bit 3 while any port shows resume detect does two things: it sets command bit 4 and status bit 2.
- R10: Reads at unimplemented offsets return 0xFFFF. These offsets are 0x0E and every port slot beyond the last port.
- R11: Enable bit 0 (offset 0x04) pairs with status bit 0, and enable bit 1 pairs with status bit 1. The other enable bits read 0. `irq` is high exactly when some status bit is set together with its paired enable bit.
- R12: Only the bytes whose strobe is high are written or cleared. Bus address bit 0 does not affect which register is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_be | input | 2 | Byte strobes: bit 0 low byte, bit 1 high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| frame_adv | input | 1 | Frame sequencer finished a frame |
| sts_set | input | 5 | Status events for status bits 0 to 4 |
| port_conn | input | NPORT | Device connected, per port |
| port_ls | input | NPORT | Low-speed device attached, per port |
| port_rdet | input | NPORT | Resume signalling seen, per port |
| run | output | 1 | Command run/stop |
| halted | output | 1 | Status halted |
| glb_reset | output | 1 | Command global reset |
| glb_suspend | output | 1 | Command enter global suspend |
| force_resume | output | 1 | Command force global resume |
| frame_num | output | FRNUM_W | Current frame number |
| fl_base | output | 32 | Frame list base address |
| sof_timing | output | 8 | Start-of-frame timing byte |
| port_en | output | NPORT | Port enable |
| port_rst | output | NPORT | Port reset |
| port_susp | output | NPORT | Port suspend |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives several corner cases:

- **Run rewritten while already running.** A design that keys halted on the written value instead of the edge would disturb halted.
- **Frame number written while running.** A missing halted gate would let the sequencer's count be overwritten.
- **Status event arriving in the same cycle as a write-one-to-clear.** Wrong precedence would lose an interrupt.
- **Frame counter stepped across 2047.** A counter wider than 11 bits would not wrap to 0.

On the ports, the bench writes ones over the read-only bits and checks that bit 7 still reads 1. It disconnects an enabled port to check that the enable clears and both change flags set. It issues a global suspend with a pending port resume, where a missing resume path would leave the controller asleep. Finally it applies a controller reset and reads back every default, which catches any register left out of the reset.

// File: rtl/usbhc_regs.sv
module usbhc_regs #(
  parameter int NPORT = 2,
  parameter int FRNUM_W = 11,
  parameter logic [7:0] SOF_DEFAULT = 8'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [4:0]         bus_addr,
  input  logic [1:0]         bus_be,
  input  logic [15:0]        bus_wdata,
  output logic [15:0]        bus_rdata,
  input  logic               frame_adv,
  input  logic [4:0]         sts_set,
  input  logic [NPORT-1:0]   port_conn,
  input  logic [NPORT-1:0]   port_ls,
  input  logic [NPORT-1:0]   port_rdet,
  output logic               run,
  output logic               halted,
  output logic               glb_reset,
  output logic               glb_suspend,
  output logic               force_resume,
  output logic [FRNUM_W-1:0] frame_num,
  output logic [31:0]        fl_base,
  output logic [7:0]         sof_timing,
  output logic [NPORT-1:0]   port_en,
  output logic [NPORT-1:0]   port_rst,
  output logic [NPORT-1:0]   port_susp,
  output logic               irq
);

  localparam logic [15:0] PORT_RW = ~16'h01BB;
  localparam int PORT_SLOT0 = 8;

  logic [4:0]         cmd, cmd_nx;
  logic [5:0]         sts, sts_nx;
  logic [1:0]         ien;
  logic [FRNUM_W-1:0] frnum;
  logic [31:0]        base;
  logic [7:0]         sof;

  logic [3:0]  wa;
  logic [15:0] bm, wbits, cmd_m, fr_m, blo_m, bhi_m;
  logic        wr_cmd, hc_rst, resume_req;
  logic [NPORT-1:0] prdet;
  logic [15:0] prd [NPORT];
  logic        unused_addr;

  assign wa    = bus_addr[4:1];
  assign bm    = {{8{bus_be[1]}}, {8{bus_be[0]}}};
  assign wbits = bus_wdata & bm;
  assign unused_addr = bus_addr[0];

  assign wr_cmd     = bus_wr && wa == 4'd0 && bus_be[0];
  assign hc_rst     = wr_cmd && bus_wdata[1];
  assign resume_req = wr_cmd && bus_wdata[3] && |prdet;

  assign cmd_m = ({11'b0, cmd} & ~bm) | wbits;
  assign fr_m  = ({{(16-FRNUM_W){1'b0}}, frnum} & ~bm) | wbits;
  assign blo_m = ((base[15:0] & ~bm) | wbits) & 16'hF000;
  assign bhi_m = (base[31:16] & ~bm) | wbits;

  always_comb begin
    cmd_nx = cmd;
    if (wr_cmd) cmd_nx = cmd_m[4:0];
    if (resume_req) cmd_nx[4] = 1'b1;
    sts_nx = sts;
    if (bus_wr && wa == 4'd1) sts_nx = sts & ~wbits[5:0];
    sts_nx[4:0] = sts_nx[4:0] | sts_set;
    if (resume_req) sts_nx[2] = 1'b1;
    if (wr_cmd) begin
      if (bus_wdata[0] && !cmd[0]) sts_nx[5] = 1'b0;
      else if (!bus_wdata[0]) sts_nx[5] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd   <= '0;
      sts   <= 6'h20;
      ien   <= '0;
      frnum <= '0;
      base  <= '0;
      sof   <= SOF_DEFAULT;
    end else if (hc_rst) begin
      cmd   <= '0;
      sts   <= 6'h20;
      ien   <= '0;
      frnum <= '0;
      base  <= '0;
      sof   <= SOF_DEFAULT;
    end else begin
      cmd <= cmd_nx;
      sts <= sts_nx;
      if (bus_wr && wa == 4'd2 && bus_be[0]) ien <= bus_wdata[1:0];
      if (bus_wr && wa == 4'd3 && sts[5]) frnum <= fr_m[FRNUM_W-1:0];
      else if (!sts[5] && frame_adv) frnum <= frnum + 1'b1;
      if (bus_wr && wa == 4'd4) base[15:0] <= blo_m;
      if (bus_wr && wa == 4'd5) base[31:16] <= bhi_m;
      if (bus_wr && wa == 4'd6 && bus_be[0]) sof <= bus_wdata[7:0];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [15:0] prw, prw_nx;
    logic        csc, enc, conn_q, csc_nx, enc_nx, psel, dis;
    logic        unused_bits;

    assign psel = bus_wr && wa == 4'(PORT_SLOT0 + p);
    assign dis  = conn_q && !port_conn[p];
    assign unused_bits = ^{prw[8:7], prw[5:3], prw[1:0]};

    always_comb begin
      prw_nx = prw;
      if (psel) prw_nx = (prw & ~(bm & PORT_RW)) | (wbits & PORT_RW);
      if (port_rdet[p]) prw_nx[6] = 1'b1;
      if (dis) prw_nx[2] = 1'b0;
      csc_nx = (csc && !(psel && wbits[1])) || (conn_q != port_conn[p]);
      enc_nx = (enc && !(psel && wbits[3])) || dis;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prw <= '0; csc <= 1'b0; enc <= 1'b0; conn_q <= 1'b0;
      end else begin
        conn_q <= port_conn[p];
        if (hc_rst) begin
          prw <= '0; csc <= 1'b0; enc <= 1'b0;
        end else begin
          prw <= prw_nx; csc <= csc_nx; enc <= enc_nx;
        end
      end
    end

    assign prd[p] = {prw[15:9], port_ls[p], 1'b1, prw[6], 2'b00, enc, prw[2], csc, conn_q};
    assign prdet[p]     = prw[6];
    assign port_en[p]   = prw[2];
    assign port_rst[p]  = prw[9];
    assign port_susp[p] = prw[12];
  end

  always_comb begin
    case (wa)
      4'd0: bus_rdata = {11'b0, cmd};
      4'd1: bus_rdata = {10'b0, sts};
      4'd2: bus_rdata = {14'b0, ien};
      4'd3: bus_rdata = {{(16-FRNUM_W){1'b0}}, frnum};
      4'd4: bus_rdata = base[15:0];
      4'd5: bus_rdata = base[31:16];
      4'd6: bus_rdata = {8'b0, sof};
      default: begin
        bus_rdata = 16'hFFFF;
        for (int p = 0; p < NPORT; p++)
          if (wa == 4'(PORT_SLOT0 + p)) bus_rdata = prd[p];
      end
    endcase
  end

  assign run          = cmd[0];
  assign glb_reset    = cmd[2];
  assign glb_suspend  = cmd[3];
  assign force_resume = cmd[4];
  assign halted       = sts[5];
  assign frame_num    = frnum;
  assign fl_base      = base;
  assign sof_timing   = sof;
  assign irq          = |(sts[1:0] & ien);

endmodule

// File: rtl/usbhc_regs_chk.sv
module usbhc_regs_chk #(
  parameter int FRNUM_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_wr,
  input logic [4:0]         bus_addr,
  input logic [1:0]         bus_be,
  input logic [15:0]        bus_wdata,
  input logic               frame_adv,
  input logic [4:0]         sts_set,
  input logic               run,
  input logic               halted,
  input logic [FRNUM_W-1:0] frame_num,
  input logic [31:0]        fl_base,
  input logic [5:0]         sts,
  input logic               irq
);

  logic hcw, en_wr, w1c_int;
  assign hcw     = bus_wr && bus_addr[4:1] == 4'd0 && bus_be[0] && bus_wdata[1];
  assign en_wr   = bus_wr && bus_addr[4:1] == 4'd2;
  assign w1c_int = bus_wr && bus_addr[4:1] == 4'd1 && bus_be[0] && bus_wdata[0] && !sts_set[0];

  AST_RUN_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !halted); // R3
  AST_STOP_SETS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> halted); // R3
  AST_FRNUM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!halted && !frame_adv) && !$past(hcw)) |-> $stable(frame_num)); // R4
  AST_FRNUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!halted && frame_adv) && !$past(hcw)) |-> frame_num == FRNUM_W'($past(frame_num) + 1'b1)); // R4
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    fl_base[11:0] == 12'h000); // R5
  AST_W1C_INT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(w1c_int) |-> !sts[0]); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(sts_set[1:0]) != 2'b00 || $past(en_wr))); // R11

endmodule

bind usbhc_regs usbhc_regs_chk #(.FRNUM_W(FRNUM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
  .bus_wdata(bus_wdata), .frame_adv(frame_adv), .sts_set(sts_set), .run(run),
  .halted(halted), .frame_num(frame_num), .fl_base(fl_base), .sts(sts), .irq(irq)
);

// File: tb/test_usbhc_regs.sv
module test_usbhc_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 2;
  localparam int NVEC = 32;
  // {write, addr[4:0], be[1:0], data[15:0], req[3:0]}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 5'h02, 2'd3, 16'h0020, 4'd2},   // R2 default halted
    {1'b0, 5'h0C, 2'd3, 16'h0040, 4'd6},   // R6 default timing
    {1'b0, 5'h00, 2'd3, 16'h0000, 4'd1},   // R1 default command
    {1'b1, 5'h0C, 2'd3, 16'h12AB, 4'd6},
    {1'b0, 5'h0C, 2'd3, 16'h00AB, 4'd6},   // R6 low byte only
    {1'b1, 5'h08, 2'd3, 16'hFFFF, 4'd5},
    {1'b0, 5'h08, 2'd3, 16'hF000, 4'd5},   // R5 alignment
    {1'b1, 5'h0A, 2'd3, 16'h1234, 4'd5},
    {1'b0, 5'h0A, 2'd3, 16'h1234, 4'd5},
    {1'b1, 5'h06, 2'd3, 16'hFFFF, 4'd4},
    {1'b0, 5'h06, 2'd3, 16'h07FF, 4'd4},   // R4 11 bits
    {1'b1, 5'h04, 2'd3, 16'hFFFF, 4'd11},
    {1'b0, 5'h04, 2'd3, 16'h0003, 4'd11},  // R11 enable width
    {1'b0, 5'h0E, 2'd3, 16'hFFFF, 4'd10},  // R10
    {1'b0, 5'h14, 2'd3, 16'hFFFF, 4'd10},
    {1'b0, 5'h1E, 2'd3, 16'hFFFF, 4'd10},
    {1'b1, 5'h00, 2'd3, 16'h0001, 4'd3},
    {1'b0, 5'h02, 2'd3, 16'h0000, 4'd3},   // R3 run clears halted
    {1'b0, 5'h00, 2'd3, 16'h0001, 4'd1},
    {1'b1, 5'h06, 2'd3, 16'h0005, 4'd4},
    {1'b0, 5'h06, 2'd3, 16'h07FF, 4'd4},   // R4 write ignored when running
    {1'b1, 5'h00, 2'd3, 16'h0001, 4'd3},
    {1'b0, 5'h02, 2'd3, 16'h0000, 4'd3},   // R3 rewrite keeps halted clear
    {1'b1, 5'h00, 2'd3, 16'h0000, 4'd3},
    {1'b0, 5'h02, 2'd3, 16'h0020, 4'd3},   // R3 stop sets halted
    {1'b1, 5'h10, 2'd3, 16'hFFFF, 4'd7},
    {1'b0, 5'h10, 2'd3, 16'hFEC4, 4'd7},   // R7 read-only mask
    {1'b1, 5'h10, 2'd3, 16'h0000, 4'd7},
    {1'b0, 5'h10, 2'd3, 16'h0080, 4'd7},
    {1'b1, 5'h0A, 2'd1, 16'hAAAA, 4'd12},
    {1'b0, 5'h0A, 2'd3, 16'h12AA, 4'd12},  // R12 byte strobe
    {1'b0, 5'h0B, 2'd3, 16'h12AA, 4'd12}   // R12 odd address
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, frame_adv = 1'b0;
  logic [4:0] bus_addr = '0, sts_set = '0;
  logic [1:0] bus_be = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [NPORT-1:0] port_conn = '0, port_ls = '0, port_rdet = '0;
  logic run, halted, glb_reset, glb_suspend, force_resume, irq;
  logic [10:0] frame_num;
  logic [31:0] fl_base;
  logic [7:0] sof_timing;
  logic [NPORT-1:0] port_en, port_rst, port_susp;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  usbhc_regs #(.NPORT(NPORT)) i_usbhc_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_adv(frame_adv), .sts_set(sts_set),
    .port_conn(port_conn), .port_ls(port_ls), .port_rdet(port_rdet), .run(run),
    .halted(halted), .glb_reset(glb_reset), .glb_suspend(glb_suspend),
    .force_resume(force_resume), .frame_num(frame_num), .fl_base(fl_base),
    .sof_timing(sof_timing), .port_en(port_en), .port_rst(port_rst),
    .port_susp(port_susp), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic expect16(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_wr(input logic [4:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk(input logic [4:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a;
    #1;
    expect16(bus_rdata, exp, tag);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect16({15'b0, irq}, 16'h0, "R11 reset irq");
    expect16({15'b0, halted}, 16'h1, "R2 reset halted");

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][27]) do_wr(VEC[i][26:22], VEC[i][21:20], VEC[i][19:4]);
      else chk(VEC[i][26:22], VEC[i][19:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
    end

    // R11 / R2 status events and interrupt
    @(negedge clk); sts_set = 5'b00001; @(negedge clk); sts_set = '0;
    chk(5'h02, 16'h0021, "R2 event sets bit0");
    expect16({15'b0, irq}, 16'h1, "R11 irq high");
    do_wr(5'h02, 2'b10, 16'h0001);
    chk(5'h02, 16'h0021, "R12 clear needs low strobe");
    do_wr(5'h02, 2'b11, 16'h0001);
    chk(5'h02, 16'h0020, "R2 write one clears");
    expect16({15'b0, irq}, 16'h0, "R11 irq low");
    @(negedge clk);
    sts_set = 5'b00010; bus_wr = 1'b1; bus_addr = 5'h02; bus_be = 2'b11; bus_wdata = 16'h0002;
    @(negedge clk);
    sts_set = '0; bus_wr = 1'b0;
    chk(5'h02, 16'h0022, "R2 event wins over clear");
    expect16({15'b0, irq}, 16'h1, "R11 error irq");
    do_wr(5'h02, 2'b11, 16'h0022);
    chk(5'h02, 16'h0000, "R2 halted cleared by write");
    expect16({15'b0, halted}, 16'h0, "R2 halted output");

    // R4 frame counting and wrap
    do_wr(5'h00, 2'b11, 16'h0000);
    do_wr(5'h06, 2'b11, 16'h07FE);
    do_wr(5'h00, 2'b11, 16'h0001);
    expect16({15'b0, run}, 16'h1, "R3 run output");
    @(negedge clk); frame_adv = 1'b1; @(negedge clk); frame_adv = 1'b0;
    chk(5'h06, 16'h07FF, "R4 frame step");
    @(negedge clk); frame_adv = 1'b1; @(negedge clk); frame_adv = 1'b0;
    chk(5'h06, 16'h0000, "R4 frame wrap");

    // R8 connect / disconnect
    @(negedge clk); port_conn[0] = 1'b1; step();
    chk(5'h10, 16'h0083, "R8 connect change");
    do_wr(5'h10, 2'b11, 16'h0004);
    chk(5'h10, 16'h0087, "R7 enable writable");
    expect16({14'b0, port_en}, 16'h0001, "R7 port_en output");
    do_wr(5'h10, 2'b11, 16'h0006);
    chk(5'h10, 16'h0085, "R8 connect change cleared");
    @(negedge clk); port_conn[0] = 1'b0; step();
    chk(5'h10, 16'h008A, "R8 disconnect");
    expect16({14'b0, port_en}, 16'h0000, "R8 enable dropped");
    do_wr(5'h10, 2'b11, 16'h000A);
    chk(5'h10, 16'h0080, "R8 change bits cleared");

    // R7 read-only bits on port 1
    @(negedge clk); port_ls[1] = 1'b1; step();
    chk(5'h12, 16'h0180, "R7 low-speed visible");
    do_wr(5'h12, 2'b11, 16'h0000);
    chk(5'h12, 16'h0180, "R7 low-speed ignores write 0");
    do_wr(5'h12, 2'b11, 16'h0101);
    chk(5'h12, 16'h0180, "R7 connect ignores write 1");

    // R9 global suspend with pending resume
    @(negedge clk); port_rdet[1] = 1'b1; @(negedge clk); port_rdet[1] = 1'b0;
    chk(5'h12, 16'h01C0, "R7 resume detect set");
    do_wr(5'h00, 2'b11, 16'h0009);
    chk(5'h00, 16'h0019, "R9 force resume set");
    chk(5'h02, 16'h0004, "R9 resume status");
    expect16({15'b0, force_resume}, 16'h1, "R9 force_resume output");

    // R1 controller reset
    do_wr(5'h00, 2'b11, 16'h0002);
    chk(5'h00, 16'h0000, "R1 cmd default");
    chk(5'h02, 16'h0020, "R1 status default");
    chk(5'h04, 16'h0000, "R1 enable default");
    chk(5'h06, 16'h0000, "R1 frame default");
    chk(5'h08, 16'h0000, "R1 base low default");
    chk(5'h0A, 16'h0000, "R1 base high default");
    chk(5'h0C, 16'h0040, "R1 timing default");
    chk(5'h12, 16'h0180, "R1 port writable bits default");
    expect16({15'b0, halted}, 16'h1, "R1 halted after reset");

    // R4 frame_adv ignored while halted
    @(negedge clk); frame_adv = 1'b1; @(negedge clk); frame_adv = 1'b0;
    chk(5'h06, 16'h0000, "R4 no step while halted");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule